// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

A single DMA channel that copies a block of bytes from a source address to a destination address over a simple memory master port. Software fills a register window with a first descriptor (addresses, byte count, link pointer) and then writes a control word whose enable bit is set. The channel moves data in beats. Each beat is one read followed by one write of the same size. When the byte count reaches zero, the channel follows the link pointer. It reads the next nine-word descriptor from memory into its own window and carries on without any software action. A zero link stops it. A link that points back to a descriptor already visited makes the channel repeat forever.

While the channel runs, software can pause it by rewriting the control word with enable clear. It can resume the transfer by setting enable again, or abort by setting the force-close bit. The window stays readable at all times. Addresses, the remaining count and the link pointer show live progress, so software can work out how much is left.

Top module: `dma_ll_channel`

## Requirements
- R1: After reset the channel is idle: `busy` and `mem_req` are low and every window word reads zero.
- R2: Window words by byte offset: 0x00 source, 0x04 destination, 0x08 byte count, 0x0C two-dimensional count, 0x10 source step, 0x14 destination step, 0x1C link, 0x20 control. Offset 0x18 and offsets above 0x20 read zero. A count above 0xFE00 is stored as 0xFE00.
- R3: Writes to words other than control are ignored while `busy` is high.
- R4: A control write with bit 0 set while idle starts the channel. A control write with bit 0 clear only stores the word.
- R5: Each beat is a read of N bytes from the source followed by a write of N bytes to the destination, with `mem_size` = log2(N). N comes from control bits 8:6 (0=1, 1=2, 2=4, 3=8 bytes; codes 4 to 7 mean 8 bytes). N drops to 1 byte when fewer than N bytes remain. Bits 15:13 are only stored.
- R6: After each write beat the source address advances by N unless control bit 2 is set. The destination address advances by N unless control bit 3 is set.
- R7: When the count reaches zero and the link is nonzero, the channel makes nine 32-bit reads (`mem_size`=2) at link+4k, k=0..8. It loads word k into window offset 4k, drops word 6 and clears bit 31 of the fetched control word. It then resumes. A zero link returns the channel to idle.
- R8: A link that points back to an earlier descriptor repeats the chain until software stops it.
- R9: A control write with bits 0 and 31 clear while busy stops all requests from the next cycle on and keeps `busy` high. Setting bit 0 again continues the same transfer.
- R10: A control write with bit 31 set makes the channel idle on the next cycle with no further requests.
- R11: `done_irq` pulses for one cycle when a descriptor whose control bit 4 is set completes.
- R12: While running and after finishing, the count, address and link words read their current values. At the end of a chain the count and link read zero.
- R13: A request that is not granted is held with the same address and direction until `mem_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset into the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | log2 of access bytes |
| mem_wdata | output | 64 | Write data, little-endian in the low bytes |
| mem_gnt | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 64 | Read data, valid in the granted cycle |
| busy | output | 1 | Channel is active or paused |
| done_irq | output | 1 | One-cycle descriptor-completion pulse |

## Verification
The bench goes after the count tail, where a byte count that is not a multiple of the beat width must fall back to single-byte beats. A design that mishandled it would read past the end of the buffer or stall with bytes left over. It chains descriptors of different widths, fixed-address modes and stalled grants. A wrong fetch base, a skipped descriptor word or a control word left unreloaded would show up at once as a stream mismatch. It pauses in the middle of a transfer, writes non-control words while busy, and force-closes a looping chain. A design that leaked a request during the pause, let a busy write corrupt an address, or kept fetching after the abort would miscompare.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;

    localparam logic [3:0] W_SRC   = 4'd0;
    localparam logic [3:0] W_DST   = 4'd1;
    localparam logic [3:0] W_CNT   = 4'd2;
    localparam logic [3:0] W_ZY    = 4'd3;
    localparam logic [3:0] W_SSTEP = 4'd4;
    localparam logic [3:0] W_DSTEP = 4'd5;
    localparam logic [3:0] W_RSVD  = 4'd6;
    localparam logic [3:0] W_LINK  = 4'd7;
    localparam logic [3:0] W_CTRL  = 4'd8;

    localparam logic [3:0] DESC_LAST_WORD = W_CTRL;

    typedef struct packed {
        logic        force_close;
        logic [14:0] spare;
        logic [2:0]  dst_w;
        logic [3:0]  burst_m1;
        logic [2:0]  src_w;
        logic [1:0]  irq_en;
        logic        dst_fix;
        logic        src_fix;
        logic        sw_req;
        logic        enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE
    } chan_state_t;

    function automatic logic [3:0] code_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    function automatic logic [1:0] beat_code(input logic [2:0] wcode, input logic [31:0] remaining);
        logic [1:0] w;
        w = (wcode > 3'd3) ? 2'd3 : wcode[1:0];
        if (remaining >= 32'(code_bytes(w)))
            return w;
        return 2'd0;
    endfunction

    function automatic logic [31:0] clamp_bytes(input logic [31:0] v, input logic [31:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/ll_addr_step.sv
module ll_addr_step
    import dma_ll_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              fixed_i,
    output logic [ADDR_W-1:0] next_o
);
    always_comb begin
        if (fixed_i)
            next_o = addr_i;
        else
            next_o = addr_i + ADDR_W'(code_bytes(size_i));
    end
endmodule

// File: rtl/ll_reg_view.sv
module ll_reg_view
    import dma_ll_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [3:0]        word_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [ADDR_W-1:0] link_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [31:0]       zy_i,
    input  logic [31:0]       sstep_i,
    input  logic [31:0]       dstep_i,
    input  ctrl_t             ctrl_i,
    output logic [31:0]       rdata_o
);
    always_comb begin
        unique case (word_i)
            W_SRC:   rdata_o = 32'(src_i);
            W_DST:   rdata_o = 32'(dst_i);
            W_CNT:   rdata_o = 32'(cnt_i);
            W_ZY:    rdata_o = zy_i;
            W_SSTEP: rdata_o = sstep_i;
            W_DSTEP: rdata_o = dstep_i;
            W_LINK:  rdata_o = 32'(link_i);
            W_CTRL:  rdata_o = ctrl_i;
            default: rdata_o = 32'd0;
        endcase
    end
endmodule

// File: rtl/dma_ll_channel.sv
module dma_ll_channel
    import dma_ll_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          CNT_W     = 16,
    parameter logic [31:0] MAX_BYTES = 32'h0000_FE00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [63:0]       mem_rdata,
    output logic              busy,
    output logic              done_irq
);
    localparam int NUM_PTR = 2;

    chan_state_t       state_q;
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] src_q, dst_q, link_q, fptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       zy_q, sstep_q, dstep_q;
    logic [3:0]        fidx_q;
    logic [63:0]       data_q;
    logic [1:0]        size_q;
    logic              done_q;

    logic [3:0]  wsel;
    logic        ctrl_wr;
    ctrl_t       wr_ctrl;
    logic        run;
    logic [1:0]  rd_code;
    logic        ld_bus, ld_fetch;
    logic [3:0]  ld_sel;
    logic [31:0] ld_val;
    logic [CNT_W-1:0] ld_cnt;

    logic [ADDR_W-1:0] ptr_cur [NUM_PTR];
    logic              ptr_fix [NUM_PTR];
    logic [ADDR_W-1:0] ptr_nxt [NUM_PTR];

    assign wsel     = reg_addr[5:2];
    assign ctrl_wr  = reg_wr && (wsel == W_CTRL);
    assign wr_ctrl  = ctrl_t'(reg_wdata);
    assign run      = ctrl_q.enable && !ctrl_wr;
    assign rd_code  = beat_code(ctrl_q.src_w, 32'(cnt_q));

    assign ld_bus   = reg_wr && !ctrl_wr && (state_q == ST_IDLE);
    assign ld_fetch = run && (state_q == ST_FETCH) && mem_gnt;
    assign ld_sel   = ld_fetch ? fidx_q : wsel;
    assign ld_val   = ld_fetch ? mem_rdata[31:0] : reg_wdata;
    assign ld_cnt   = CNT_W'(clamp_bytes(ld_val, MAX_BYTES));

    assign ptr_cur[0] = src_q;
    assign ptr_cur[1] = dst_q;
    assign ptr_fix[0] = ctrl_q.src_fix;
    assign ptr_fix[1] = ctrl_q.dst_fix;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_step
        ll_addr_step #(.ADDR_W(ADDR_W)) u_step (
            .addr_i  (ptr_cur[g]),
            .size_i  (size_q),
            .fixed_i (ptr_fix[g]),
            .next_o  (ptr_nxt[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            link_q  <= '0;
            fptr_q  <= '0;
            cnt_q   <= '0;
            zy_q    <= '0;
            sstep_q <= '0;
            dstep_q <= '0;
            fidx_q  <= '0;
            data_q  <= '0;
            size_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;

            if (ctrl_wr) begin
                ctrl_q <= wr_ctrl;
                if (wr_ctrl.force_close) begin
                    ctrl_q.enable      <= 1'b0;
                    ctrl_q.force_close <= 1'b0;
                    state_q            <= ST_IDLE;
                end else if (state_q == ST_IDLE && wr_ctrl.enable) begin
                    state_q <= ST_READ;
                end
            end

            if (ld_bus || ld_fetch) begin
                case (ld_sel)
                    W_SRC:   src_q   <= ld_val[ADDR_W-1:0];
                    W_DST:   dst_q   <= ld_val[ADDR_W-1:0];
                    W_CNT:   cnt_q   <= ld_cnt;
                    W_ZY:    zy_q    <= ld_val;
                    W_SSTEP: sstep_q <= ld_val;
                    W_DSTEP: dstep_q <= ld_val;
                    W_LINK:  link_q  <= ld_val[ADDR_W-1:0];
                    W_CTRL: begin
                        if (ld_fetch) begin
                            ctrl_q             <= ctrl_t'(ld_val);
                            ctrl_q.force_close <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end

            if (run) begin
                case (state_q)
                    ST_READ: begin
                        if (cnt_q == '0) begin
                            done_q <= ctrl_q.irq_en[0];
                            if (link_q == '0) begin
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_FETCH;
                                fptr_q  <= link_q;
                                fidx_q  <= '0;
                            end
                        end else if (mem_gnt) begin
                            data_q  <= mem_rdata;
                            size_q  <= rd_code;
                            state_q <= ST_WRITE;
                        end
                    end
                    ST_WRITE: begin
                        if (mem_gnt) begin
                            src_q   <= ptr_nxt[0];
                            dst_q   <= ptr_nxt[1];
                            cnt_q   <= cnt_q - CNT_W'(code_bytes(size_q));
                            state_q <= ST_READ;
                        end
                    end
                    ST_FETCH: begin
                        if (mem_gnt) begin
                            if (fidx_q == DESC_LAST_WORD)
                                state_q <= ST_READ;
                            else
                                fidx_q <= fidx_q + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = 2'd0;
        mem_wdata = data_q;
        case (state_q)
            ST_FETCH: begin
                mem_req  = run;
                mem_addr = fptr_q + ADDR_W'({fidx_q, 2'b00});
                mem_size = 2'd2;
            end
            ST_READ: begin
                mem_req  = run && (cnt_q != '0);
                mem_addr = src_q;
                mem_size = rd_code;
            end
            ST_WRITE: begin
                mem_req  = run;
                mem_we   = 1'b1;
                mem_addr = dst_q;
                mem_size = size_q;
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign done_irq = done_q;

    ll_reg_view #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_view (
        .word_i  (wsel),
        .src_i   (src_q),
        .dst_i   (dst_q),
        .link_i  (link_q),
        .cnt_i   (cnt_q),
        .zy_i    (zy_q),
        .sstep_i (sstep_q),
        .dstep_i (dstep_q),
        .ctrl_i  (ctrl_q),
        .rdata_o (reg_rdata)
    );
endmodule

// File: rtl/dma_ll_channel_chk.sv
module dma_ll_channel_chk #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] MAX_BYTES = 32'h0000_FE00
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [5:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              busy,
    input logic              done_irq
);
    logic ctrl_sel;
    assign ctrl_sel = reg_wr && (reg_addr[5:2] == 4'd8);

    // R1 / R4: an idle channel never requests
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R2: stored count never exceeds the per-descriptor maximum
    p_count_cap_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[5:2] == 4'd2) |-> (reg_rdata <= MAX_BYTES));

    // R9: pause keeps the channel busy and silent on the next cycle
    p_pause_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_sel && !reg_wdata[31] && !reg_wdata[0]) |=> (busy && !mem_req));

    // R10: force close drops the channel at once
    p_force_stop_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_sel && reg_wdata[31]) |=> (!busy && !mem_req));

    // R11: completion pulse lasts one cycle
    p_irq_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);

    // R13: an ungranted request holds its address and direction
    p_stall_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt && !reg_wr) |=>
            (reg_wr || (mem_req && $stable(mem_addr) && $stable(mem_we))));
endmodule

bind dma_ll_channel dma_ll_channel_chk #(
    .ADDR_W    (ADDR_W),
    .MAX_BYTES (MAX_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_gnt   (mem_gnt),
    .busy      (busy),
    .done_irq  (done_irq)
);

// File: tb/test_dma_ll_channel.sv
module test_dma_ll_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata;
    logic        mem_gnt = 1'b1;
    logic [63:0] mem_rdata;
    logic        busy, done_irq;

    int vectors = 0;
    int fails = 0;
    int irq_seen = 0;
    logic stall_en = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    logic [7:0] mem     [4096];
    logic [7:0] ref_mem [4096];

    typedef struct {
        bit we;
        int addr;
        int size;
    } xact_t;
    xact_t exp_q[$];

    always #2 clk = ~clk;

    dma_ll_channel i_dma_ll_channel (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done_irq  (done_irq)
    );

    always_comb begin
        for (int i = 0; i < 8; i++)
            mem_rdata[8*i +: 8] = mem[(int'(mem_addr) + i) & 4095];
    end

    task automatic report(string req, string what, longint act, longint exp);
        fails++;
        $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    endtask

    task automatic check(string req, string what, longint act, longint exp);
        vectors++;
        if (act != exp) report(req, what, act, exp);
    endtask

    // reference comparison of the bus stream on every clock
    always @(negedge clk) begin
        xact_t x;
        if (!rst) begin
            if (done_irq) irq_seen++;
            if (mem_req && !busy) report("R1", "request while idle", 1, 0);
            if (mem_req && mem_gnt) begin
                vectors++;
                if (exp_q.size() == 0) begin
                    report("R7", "unexpected access at", longint'(mem_addr), 0);
                end else begin
                    x = exp_q.pop_front();
                    if (x.we != mem_we || x.addr != int'(mem_addr) || x.size != int'(mem_size)) begin
                        report("R5/R6/R7", "access {we,size,addr}",
                               {31'd0, mem_we, 2'd0, mem_size, mem_addr},
                               {31'd0, x.we, 2'd0, 2'(x.size), 32'(x.addr)});
                    end
                end
                if (mem_we) begin
                    for (int k = 0; k < (1 << mem_size); k++)
                        mem[(int'(mem_addr) + k) & 4095] = mem_wdata[8*k +: 8];
                end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_gnt = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        report("WDOG", "watchdog expired", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    task automatic reg_write(int word, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 6'(word * 4); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(int word, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = 6'(word * 4);
        #1;
        d = reg_rdata;
    endtask

    task automatic put_word(int a, logic [31:0] v);
        for (int k = 0; k < 4; k++) begin
            mem[(a + k) & 4095]     = v[8*k +: 8];
            ref_mem[(a + k) & 4095] = v[8*k +: 8];
        end
    endtask

    task automatic put_desc(int base, int s, int d, int c, int link, logic [31:0] ctl);
        put_word(base + 0,  32'(s));
        put_word(base + 4,  32'(d));
        put_word(base + 8,  32'(c));
        put_word(base + 12, 32'h0);
        put_word(base + 16, 32'h0);
        put_word(base + 20, 32'h0);
        put_word(base + 24, 32'hDEAD_BEEF);
        put_word(base + 28, 32'(link));
        put_word(base + 32, ctl);
    endtask

    task automatic push(bit we, int a, int sz);
        xact_t x;
        x.we = we; x.addr = a; x.size = sz;
        exp_q.push_back(x);
    endtask

    task automatic model_desc(int s, int d, int c, logic [31:0] ctl);
        int w;
        int sz;
        int b;
        w = (ctl[8:6] > 3) ? 3 : int'(ctl[8:6]);
        while (c > 0) begin
            sz = (c < (1 << w)) ? 0 : w;
            b  = 1 << sz;
            push(1'b0, s, sz);
            push(1'b1, d, sz);
            for (int k = 0; k < b; k++)
                ref_mem[(d + k) & 4095] = ref_mem[(s + k) & 4095];
            if (!ctl[2]) s += b;
            if (!ctl[3]) d += b;
            c -= b;
        end
    endtask

    task automatic model_fetch(int link);
        for (int k = 0; k < 9; k++) push(1'b0, link + 4 * k, 2);
    endtask

    task automatic load_regs(int s, int d, int c, int link);
        reg_write(0, 32'(s));
        reg_write(1, 32'(d));
        reg_write(2, 32'(c));
        reg_write(7, 32'(link));
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (busy) begin
            @(posedge clk); #1;
        end
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic compare_mem(string req);
        int bad = 0;
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== ref_mem[i]) bad++;
        check(req, "memory bytes differing", bad, 0);
    endtask

    initial begin
        logic [31:0] rv;
        int irq_base;

        for (int i = 0; i < 4096; i++) begin
            mem[i]     = 8'((i * 7 + 3) & 255);
            ref_mem[i] = 8'((i * 7 + 3) & 255);
        end

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check("R1", "busy after reset", busy, 0);
        check("R1", "mem_req after reset", mem_req, 0);
        reg_read(0, rv); check("R1", "source after reset", rv, 0);
        reg_read(7, rv); check("R1", "link after reset", rv, 0);
        reg_read(8, rv); check("R1", "control after reset", rv, 0);

        // R2: window layout and count clamp
        reg_write(2, 32'h0000_FFFF);
        reg_read(2, rv); check("R2", "clamped count", rv, 32'hFE00);
        reg_write(2, 32'h0000_1234);
        reg_read(2, rv); check("R2", "plain count", rv, 32'h1234);
        reg_write(3, 32'h0000_ABCD);
        reg_read(3, rv); check("R2", "zy count word", rv, 32'hABCD);
        reg_write(6, 32'h1111_2222);
        reg_read(6, rv); check("R2", "reserved offset reads zero", rv, 0);
        // R4: control write with enable clear does not start
        reg_write(8, 32'h0000_4090);
        reg_read(8, rv); check("R4", "stored control", rv, 32'h4090);
        check("R4", "busy after disabled control write", busy, 0);

        // R5 R11 R12: one descriptor, 4-byte beats with a byte tail
        irq_base = irq_seen;
        load_regs(32'h100, 32'h400, 22, 0);
        model_desc(32'h100, 32'h400, 22, 32'h4091);
        reg_write(8, 32'h0000_4091);
        check("R4", "busy after start", busy, 1);
        wait_idle();
        check("R5", "pending accesses", exp_q.size(), 0);
        compare_mem("R5");
        check("R11", "completion pulses", irq_seen - irq_base, 1);
        reg_read(2, rv); check("R12", "count at end", rv, 0);
        reg_read(0, rv); check("R12", "source at end", rv, 32'h116);
        reg_read(7, rv); check("R12", "link at end", rv, 0);

        // R3 R6 R7 R13: three-descriptor chain with mixed widths and stalls
        stall_en = 1'b1;
        irq_base = irq_seen;
        put_desc(32'h800, 32'h180, 32'h4C0, 24, 32'h840, 32'h0000_61C5);
        put_desc(32'h840, 32'h1C0, 32'h500, 5, 0, 32'h0000_0019);
        load_regs(32'h140, 32'h480, 13, 32'h800);
        model_desc(32'h140, 32'h480, 13, 32'h0000_2041);
        model_fetch(32'h800);
        model_desc(32'h180, 32'h4C0, 24, 32'h0000_61C5);
        model_fetch(32'h840);
        model_desc(32'h1C0, 32'h500, 5, 32'h0000_0019);
        reg_write(8, 32'h0000_2041);
        reg_write(0, 32'h0000_03F0);
        reg_write(2, 32'h0000_0000);
        wait_idle();
        stall_en = 1'b0;
        check("R7", "pending accesses after chain", exp_q.size(), 0);
        compare_mem("R6");
        check("R11", "pulses on chain (last only)", irq_seen - irq_base, 1);
        reg_read(1, rv); check("R6", "fixed destination held", rv, 32'h500);
        reg_read(0, rv); check("R3", "source after ignored write", rv, 32'h1C5);
        reg_read(7, rv); check("R12", "link after chain", rv, 0);
        reg_read(8, rv); check("R7", "control reloaded from memory", rv, 32'h19);

        // R9: pause and resume
        irq_base = irq_seen;
        load_regs(32'h200, 32'h600, 200, 0);
        model_desc(32'h200, 32'h600, 200, 32'h11);
        reg_write(8, 32'h11);
        repeat (40) @(posedge clk);
        reg_write(8, 32'h10);
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            check("R9", "busy while paused", busy, 1);
            check("R9", "request while paused", mem_req, 0);
        end
        reg_read(2, rv);
        check("R12", "live count mid-transfer", (rv > 0 && rv < 200) ? 1 : 0, 1);
        reg_write(8, 32'h11);
        wait_idle();
        check("R9", "pending accesses after resume", exp_q.size(), 0);
        compare_mem("R9");
        check("R11", "pulse after resumed transfer", irq_seen - irq_base, 1);

        // R8 R10: looping chain, then force close
        irq_base = irq_seen;
        put_desc(32'h880, 32'h300, 32'h700, 8, 32'h880, 32'h0000_4091);
        load_regs(32'h300, 32'h700, 8, 32'h880);
        model_desc(32'h300, 32'h700, 8, 32'h4091);
        for (int lap = 0; lap < 8; lap++) begin
            model_fetch(32'h880);
            model_desc(32'h300, 32'h700, 8, 32'h4091);
        end
        reg_write(8, 32'h0000_4091);
        while (irq_seen - irq_base < 4) begin
            @(posedge clk); #1;
        end
        check("R8", "chain still busy after four laps", busy, 1);
        reg_write(8, 32'h8000_0000);
        check("R10", "busy after force close", busy, 0);
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            check("R10", "request after force close", mem_req, 0);
        end
        check("R8", "loop had accesses left", (exp_q.size() > 0) ? 1 : 0, 1);
        exp_q.delete();
        compare_mem("R8");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule